// File: doc/BRIEF.md
# Z80 Instruction Length and Legality Decoder

This block looks at the first bytes of a Z80 instruction while they are still being fetched. It reports one of three results: more bytes are needed, the sequence is illegal, or the sequence is a legal instruction. For a legal instruction it also reports a group code and the total length in bytes. That length counts every prefix byte, any displacement and any 8-bit or 16-bit immediate operand. A fetch sequencer calls it after each opcode byte and uses the result to decide whether to fetch another opcode byte, fetch operands, or raise an illegal-instruction trap.

The block is purely combinational. It reads a four-byte window, with byte k on bits 8k+7 to 8k, and a two-bit index that names the last valid byte. Index value v means bytes 0 to v are present. There is one exception: when bytes 0 and 1 are DD CB or FD CB, the index value 2 means the final opcode at byte 3 is present. Byte 2 (the displacement) is never examined. The decoder covers the plain page, the CB, ED, DD and FD pages, and the indexed bit page. Each non-plain page has its own decode path, and the indexed bit page has a dedicated sub-decoder for its fourth byte.

Top module: `z80len_decoder`

## Requirements
- R1: The outcome is always one of 2'b00 (need more), 2'b01 (illegal) or 2'b10 (legal). When the outcome is not legal, the group and the length are both 0.
- R2: If byte 0 is not one of CB, ED, DD or FD, the outcome is legal at every index value. Length is 3 for the 16-bit immediate, absolute-address and jump/call forms, 2 for the relative-jump, 8-bit immediate and port-immediate forms, and 1 otherwise. The group is {3'd0, byte0[7:6]}.
- R3: If byte 0 is CB, ED, DD or FD and the index is 0, the outcome is need more.
- R4: CB then any byte, with index at least 1, is legal with length 2 and group {3'd1, byte1[7:6]}.
- R5: ED then byte1, with index at least 1, is legal only for 40-7F other than 77 and 7F, and for A0-A3, A8-AB, B0-B3 and B8-BB. The length is 4 for 43, 4B, 53, 5B, 63, 6B, 73 and 7B, and 2 for the others. The group is {3'd2, byte1[7:6]}. Every other byte1 is illegal.
- R6: DD or FD then a byte other than CB, DD, ED or FD, with index at least 1, is legal. Its length is the plain length of byte1 plus 1, plus one more when byte1 reads or writes memory through the HL pointer (34, 35, 36, 46, 4E, 56, 5E, 66, 6E, 7E, 70-75, 77, 86, 8E, 96, 9E, A6, AE, B6, BE). The group is {3'd3, byte1[7:6]}.
- R7: DD or FD followed by DD, ED or FD, with index at least 1, is illegal.
- R8: DD CB or FD CB with index 1 gives need more. With index 2, the decision uses byte 3 only, and byte 2 has no effect.
- R9: For DD CB or FD CB at index 2, the outcome is legal exactly when byte3[2:0] is 3'b110. A legal result has length 4 and group {3'd4, byte3[7:6]}.
- R10: Bytes beyond those the decision needs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| win_i | input | 32 | Fetched bytes; byte k on bits 8k+7:8k |
| last_i | input | 2 | Index of the last valid byte (0 to 2) |
| outcome_o | output | 2 | 00 need more, 01 illegal, 10 legal |
| group_o | output | 5 | Page code in [4:2], final opcode bits 7:6 in [1:0] |
| len_o | output | 3 | Total instruction length in bytes when legal |

## Verification
The embedded checks are immediate assertions on a combinational path. They assume the window and the index have settled, and that the index never takes the value 3. The bench changes inputs only one time unit after a rising edge and compares at the falling edge. It drives only the index values 0, 1 and 2, with random contents in the bytes the decision must ignore. Sweeps go over every value of the deciding byte in each page.

// File: rtl/z80len_pkg.sv
package z80len_pkg;
  localparam int BYTE_W    = 8;
  localparam int WIN_BYTES = 4;
  localparam int WIN_W     = BYTE_W * WIN_BYTES;
  localparam int CNT_W     = 2;
  localparam int LEN_W     = 3;
  localparam int PAGE_W    = 3;
  localparam int GRP_W     = PAGE_W + 2;

  typedef enum logic [1:0] {
    OUT_MORE    = 2'b00,
    OUT_ILLEGAL = 2'b01,
    OUT_LEGAL   = 2'b10
  } outcome_e;

  typedef enum logic [PAGE_W-1:0] {
    PG_BASE   = 3'd0,
    PG_BIT    = 3'd1,
    PG_EXT    = 3'd2,
    PG_IDX    = 3'd3,
    PG_IDXBIT = 3'd4
  } page_e;

  localparam logic [BYTE_W-1:0] PFX_BIT = 8'hCB;
  localparam logic [BYTE_W-1:0] PFX_EXT = 8'hED;
  localparam logic [BYTE_W-1:0] PFX_IX  = 8'hDD;
  localparam logic [BYTE_W-1:0] PFX_IY  = 8'hFD;
endpackage

// File: rtl/z80len_base.sv
// Plain-page opcode: length without prefix and HL-pointer memory use.
module z80len_base
  import z80len_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              hlmem_o
);
  logic [1:0] qd;
  logic [2:0] mid, low;

  assign qd  = op_i[7:6];
  assign mid = op_i[5:3];
  assign low = op_i[2:0];

  always_comb begin
    len_o = LEN_W'(1);
    case (qd)
      2'd0: begin
        case (low)
          3'd0: if (mid >= 3'd2) len_o = LEN_W'(2);
          3'd1: if (!mid[0])     len_o = LEN_W'(3);
          3'd2: if (mid[2])      len_o = LEN_W'(3);
          3'd6:                  len_o = LEN_W'(2);
          default: ;
        endcase
      end
      2'd3: begin
        case (low)
          3'd2, 3'd4: len_o = LEN_W'(3);
          3'd3: begin
            if (mid == 3'd0) len_o = LEN_W'(3);
            else if (mid == 3'd2 || mid == 3'd3) len_o = LEN_W'(2);
          end
          3'd5: if (mid == 3'd1) len_o = LEN_W'(3);
          3'd6: len_o = LEN_W'(2);
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_comb begin
    case (qd)
      2'd0:    hlmem_o = (mid == 3'd6) && (low >= 3'd4) && (low <= 3'd6);
      2'd1:    hlmem_o = (mid == 3'd6) != (low == 3'd6);
      2'd2:    hlmem_o = (low == 3'd6);
      default: hlmem_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/z80len_ext.sv
// ED page: defined-opcode check and total length (prefix included).
module z80len_ext
  import z80len_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output logic              ok_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [2:0] mid, low;
  assign mid = op_i[5:3];
  assign low = op_i[2:0];

  always_comb begin
    ok_o  = 1'b0;
    len_o = LEN_W'(2);
    case (op_i[7:6])
      2'd1: begin
        ok_o = !((low == 3'd7) && mid[2] && mid[1]);
        if (low == 3'd3) len_o = LEN_W'(4);
      end
      2'd2: ok_o = mid[2] && !low[2];
      default: ;
    endcase
  end
endmodule

// File: rtl/z80len_idxbit.sv
// Fourth byte of an indexed bit instruction: legality only.
module z80len_idxbit
  import z80len_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output logic              ok_o
);
  assign ok_o = (op_i[2:0] == 3'b110);
endmodule

// File: rtl/z80len_decoder.sv
module z80len_decoder
  import z80len_pkg::*;
(
  input  logic [WIN_W-1:0]  win_i,
  input  logic [CNT_W-1:0]  last_i,
  output logic [1:0]        outcome_o,
  output logic [GRP_W-1:0]  group_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [BYTE_W-1:0] bt [WIN_BYTES];

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_bytes
    assign bt[k] = win_i[k*BYTE_W +: BYTE_W];
  end

  // the displacement byte never takes part in the decision
  logic disp_unused;
  assign disp_unused = ^bt[2];

  logic have1, have3, idx0;
  assign have1 = (last_i != '0);
  assign have3 = last_i[1];
  assign idx0  = (bt[0] == PFX_IX) || (bt[0] == PFX_IY);

  logic [BYTE_W-1:0] base_op;
  logic [LEN_W-1:0]  base_len, ext_len;
  logic              base_hlmem, ext_ok, ib_ok;

  assign base_op = idx0 ? bt[1] : bt[0];

  z80len_base u_base (
    .op_i    (base_op),
    .len_o   (base_len),
    .hlmem_o (base_hlmem)
  );

  z80len_ext u_ext (
    .op_i  (bt[1]),
    .ok_o  (ext_ok),
    .len_o (ext_len)
  );

  z80len_idxbit u_idxbit (
    .op_i (bt[3]),
    .ok_o (ib_ok)
  );

  outcome_e          oc;
  page_e             page;
  logic [BYTE_W-1:0] fop;
  logic [LEN_W-1:0]  ln;

  always_comb begin
    oc   = OUT_LEGAL;
    page = PG_BASE;
    fop  = bt[0];
    ln   = base_len;
    if (bt[0] == PFX_BIT) begin
      page = PG_BIT;
      fop  = bt[1];
      ln   = LEN_W'(2);
      if (!have1) oc = OUT_MORE;
    end else if (bt[0] == PFX_EXT) begin
      page = PG_EXT;
      fop  = bt[1];
      ln   = ext_len;
      if (!have1)       oc = OUT_MORE;
      else if (!ext_ok) oc = OUT_ILLEGAL;
    end else if (idx0) begin
      page = PG_IDX;
      fop  = bt[1];
      ln   = base_len + LEN_W'(1) + LEN_W'(base_hlmem);
      if (!have1) begin
        oc = OUT_MORE;
      end else if (bt[1] == PFX_IX || bt[1] == PFX_IY || bt[1] == PFX_EXT) begin
        oc = OUT_ILLEGAL;
      end else if (bt[1] == PFX_BIT) begin
        page = PG_IDXBIT;
        fop  = bt[3];
        ln   = LEN_W'(4);
        if (!have3)      oc = OUT_MORE;
        else if (!ib_ok) oc = OUT_ILLEGAL;
      end
    end
  end

  assign outcome_o = oc;
  assign group_o   = (oc == OUT_LEGAL) ? {page, fop[7:6]} : '0;
  assign len_o     = (oc == OUT_LEGAL) ? ln : '0;

  // embedded checks on the settled outputs
  always_comb begin
    if (!$isunknown({win_i, last_i})) begin
      a_r1_one_outcome: assert (outcome_o != 2'b11);
      a_r1_quiet_unless_legal: assert (outcome_o == OUT_LEGAL || (len_o == '0 && group_o == '0));
      a_r3_prefix_waits: assert (have1 || !(idx0 || bt[0] == PFX_BIT || bt[0] == PFX_EXT)
                                 || outcome_o == OUT_MORE);
      a_r4_bit_len: assert (!(outcome_o == OUT_LEGAL && group_o[4:2] == PG_BIT) || len_o == LEN_W'(2));
      a_r5_ext_len: assert (!(outcome_o == OUT_LEGAL && group_o[4:2] == PG_EXT)
                            || len_o == LEN_W'(2) || len_o == LEN_W'(4));
      a_r6_idx_len: assert (!(outcome_o == OUT_LEGAL && group_o[4:2] == PG_IDX)
                            || (len_o >= LEN_W'(2) && len_o <= LEN_W'(4)));
      a_r9_idxbit_form: assert (!(outcome_o == OUT_LEGAL && group_o[4:2] == PG_IDXBIT)
                                || (len_o == LEN_W'(4) && bt[3][2:0] == 3'b110));
    end
  end
endmodule

// File: tb/z80len_decoder_tb.sv
module z80len_decoder_tb_top;
  logic        clk;
  logic [31:0] win;
  logic [1:0]  last;
  logic [1:0]  outcome;
  logic [4:0]  grp;
  logic [2:0]  len;
  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  z80len_decoder dut_i (
    .win_i     (win),
    .last_i    (last),
    .outcome_o (outcome),
    .group_o   (grp),
    .len_o     (len)
  );

  function automatic int plain_len(int op);
    if (op inside {'h01,'h11,'h21,'h31,'h22,'h2A,'h32,'h3A,'hC3,'hCD,
                   'hC2,'hCA,'hD2,'hDA,'hE2,'hEA,'hF2,'hFA,
                   'hC4,'hCC,'hD4,'hDC,'hE4,'hEC,'hF4,'hFC}) return 3;
    if (op inside {'h10,'h18,'h20,'h28,'h30,'h38,
                   'h06,'h0E,'h16,'h1E,'h26,'h2E,'h36,'h3E,'hD3,'hDB,
                   'hC6,'hCE,'hD6,'hDE,'hE6,'hEE,'hF6,'hFE}) return 2;
    return 1;
  endfunction

  function automatic bit hl_mem(int op);
    return op inside {'h34,'h35,'h36,'h46,'h4E,'h56,'h5E,'h66,'h6E,'h7E,
                      ['h70:'h75],'h77,'h86,'h8E,'h96,'h9E,'hA6,'hAE,'hB6,'hBE};
  endfunction

  // reference: exp outcome 0 more / 1 illegal / 2 legal; tag names requirement
  task automatic model(input logic [31:0] w, input int lv,
                       output int eo, output int eg, output int el, output string tag);
    int b0, b1, b3, page, op;
    b0 = int'(w[7:0]); b1 = int'(w[15:8]); b3 = int'(w[31:24]);
    eo = 2; page = 0; op = b0; el = 0;
    if (b0 == 'hCB) begin
      tag = "R4"; page = 1; op = b1; el = 2;
      if (lv == 0) begin eo = 0; tag = "R3"; end
    end else if (b0 == 'hED) begin
      tag = "R5"; page = 2; op = b1;
      if (lv == 0) begin eo = 0; tag = "R3"; end
      else if ((b1 >= 'h40 && b1 <= 'h7F && b1 != 'h77 && b1 != 'h7F) ||
               b1 inside {['hA0:'hA3],['hA8:'hAB],['hB0:'hB3],['hB8:'hBB]})
        el = (b1 inside {'h43,'h4B,'h53,'h5B,'h63,'h6B,'h73,'h7B}) ? 4 : 2;
      else eo = 1;
    end else if (b0 == 'hDD || b0 == 'hFD) begin
      if (lv == 0) begin eo = 0; tag = "R3"; end
      else if (b1 == 'hDD || b1 == 'hFD || b1 == 'hED) begin eo = 1; tag = "R7"; end
      else if (b1 == 'hCB) begin
        page = 4; op = b3;
        if (lv < 2) begin eo = 0; tag = "R8"; end
        else begin
          tag = "R9";
          if ((b3 % 8) == 6) el = 4; else eo = 1;
        end
      end else begin
        tag = "R6"; page = 3; op = b1;
        el = plain_len(b1) + 1 + (hl_mem(b1) ? 1 : 0);
      end
    end else begin
      tag = "R2"; el = plain_len(b0);
    end
    eg = (eo == 2) ? page * 4 + op / 64 : 0;
    if (eo != 2) el = 0;
  endtask

  task automatic check_one(input logic [31:0] w, input int lv, input string extra);
    int eo, eg, el;
    string tag;
    @(posedge clk);
    #1;
    win  = w;
    last = 2'(lv);
    @(negedge clk);
    model(w, lv, eo, eg, el, tag);
    checks++;
    if (int'(outcome) != eo || int'(grp) != eg || int'(len) != el) begin
      failures++;
      $display("FAIL %s%s win=%h last=%0d: got outcome=%0d group=%0d len=%0d, expected outcome=%0d group=%0d len=%0d",
               tag, extra, w, lv, outcome, grp, len, eo, eg, el);
    end
  endtask

  function automatic logic [31:0] mk(int b0, int b1, int b2, int b3);
    return {8'(b3), 8'(b2), 8'(b1), 8'(b0)};
  endfunction

  initial begin
    win  = '0;
    last = '0;
    // R1: idle vector (all zero) must be a one-byte plain instruction
    check_one(32'h0, 0, "/R1 idle");
    // R2 / R10: every plain opcode at each index, tail bytes random
    for (int op = 0; op < 256; op++) begin
      for (int lv = 0; lv < 3; lv++)
        check_one(mk(op, $urandom, $urandom, $urandom), lv, "/R10");
    end
    // R3 to R7: each prefix with every second byte
    for (int p = 0; p < 4; p++) begin
      int pf;
      pf = (p == 0) ? 'hCB : (p == 1) ? 'hED : (p == 2) ? 'hDD : 'hFD;
      for (int op = 0; op < 256; op++) begin
        for (int lv = 0; lv < 3; lv++)
          check_one(mk(pf, op, $urandom, $urandom), lv, "");
      end
    end
    // R8 / R9: indexed bit form, every fourth byte, random displacement
    for (int op = 0; op < 256; op++) begin
      for (int lv = 0; lv < 3; lv++) begin
        check_one(mk('hDD, 'hCB, $urandom, op), lv, "");
        check_one(mk('hFD, 'hCB, $urandom, op), lv, "");
      end
    end
    // R8: displacement change alone leaves the result unchanged
    check_one(mk('hDD, 'hCB, 'h00, 'h46), 2, "/disp");
    check_one(mk('hDD, 'hCB, 'hFF, 'h46), 2, "/disp");
    check_one(mk('hFD, 'hCB, 'h80, 'h47), 2, "/disp");
    // R6: explicit corners
    check_one(mk('hDD, 'h36, 'h05, 'h99), 1, "/ld-mem-imm");
    check_one(mk('hFD, 'h21, 'h00, 'h00), 1, "/ld-rp-imm");
    check_one(mk('hDD, 'h76, 'h00, 'h00), 1, "/halt-form");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no completion, expected completion within 200000 cycles");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule